// File: doc/BRIEF.md
# Sub-Domain Bridge Enable Sequencer

This controller brings one child block that sits inside an already powered island into service and takes it back out. It owns four control lines toward that block: the reset (active high), the clock enable, and the stop requests of two asynchronous bus bridges. One bridge faces the master side and the other faces the slave side. Each bridge answers with an acknowledge that is high while the bridge is stopped. Those acknowledges arrive from another clock domain, so the controller passes them through a synchronizer before it looks at them.

A one-cycle turn-on pulse runs a fixed sequence. The clock first runs with reset held, so that reset can propagate. The clock is then gated, reset is released with the clock stopped, and the clock is enabled again. After that the master bridge is opened, and the slave bridge is opened once the master has answered. A turn-off pulse runs the reverse order and finishes by gating the clock and asserting reset. A reset pulse runs a complete turn-off and then a complete turn-on. Every acknowledge wait has a timeout. Each failure path undoes only the steps that were already taken, and it ends with a one-cycle error pulse. A successful sequence ends with a one-cycle done pulse.

A parameter can build the controller for a sub-domain that has no bridges. In that build the stop requests stay asserted, and only the clock and reset steps run.

Top module: `subdom_seq`

## Requirements
- R1: On turn-on, the clock enable is high while reset is asserted for exactly RST_CYCLES consecutive cycles. The clock is then gated before reset is released.
- R2: Reset is released only in a cycle where the clock enable is low. The clock enable rises again after reset has been released.
- R3: The master stop request is cleared while the slave stop request is still high. The slave stop request is cleared only after the synchronized master acknowledge has gone low. When the slave acknowledge goes low, the sequencer pulses done and `powered_o` rises.
- R4: If the master acknowledge does not fall within ACK_TIMEOUT cycles during turn-on, the sequencer does the following:
  - it pulses err;
  - it re-asserts the master stop request;
  - it gates the clock and asserts reset;
  - it leaves `powered_o` low.
- R5: If the slave acknowledge does not fall within ACK_TIMEOUT cycles during turn-on, the sequencer stops both bridges. It then waits for the master acknowledge to rise, or for a timeout. After that it gates the clock, asserts reset and pulses err.
- R6: On turn-off, the slave stop request is raised first. The master stop request is raised only after the slave acknowledge has risen, and it is never raised while the slave stop request is low. When the master acknowledge rises, the clock is gated, reset is asserted and done pulses.
- R7: If the master acknowledge does not rise within ACK_TIMEOUT cycles during turn-off, the slave stop request is cleared again and err pulses. The clock enable, reset and `powered_o` keep their powered values. If the slave acknowledge times out instead, its stop request is cleared again and err pulses.
- R8: A reset request in the powered state runs a full turn-off and then a full turn-on. Reset is asserted during the sequence, and a single done pulse comes at the end.
- R9: A turn-on request is ignored while the sub-domain is powered. A turn-off or reset request is ignored while it is unpowered. In both cases no done or err pulse appears, and the outputs do not change.
- R10: With HAS_BRIDGE=0, both stop requests stay high. A turn-on completes through the clock and reset steps alone, with done, and a turn-off ends with the clock gated and reset asserted.
- R11: `in_reset_o` is high exactly when the block reset output is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Turn-on request pulse |
| off_req_i | input | 1 | Turn-off request pulse |
| rst_req_i | input | 1 | Sub-block reset request pulse |
| m_ack_i | input | 1 | Master bridge stopped acknowledge (asynchronous) |
| s_ack_i | input | 1 | Slave bridge stopped acknowledge (asynchronous) |
| blk_rst_o | output | 1 | Reset to the child block, active high |
| clk_en_o | output | 1 | Clock enable to the child block |
| m_stop_o | output | 1 | Master bridge stop request |
| s_stop_o | output | 1 | Slave bridge stop request |
| powered_o | output | 1 | Child block is in service |
| in_reset_o | output | 1 | Child block is held in reset |
| done_o | output | 1 | Sequence completed, one cycle |
| err_o | output | 1 | Sequence failed and rolled back, one cycle |

## Verification
The ordering assertions take two things for granted. First, each bridge acknowledge follows its own stop request and never moves on its own accord. Second, requests are single-cycle pulses. The bench's bridge model only copies the stop line into the acknowledge, after a random delay well inside ACK_TIMEOUT, or it freezes the acknowledge to force a timeout. Requests are pulsed for one cycle, and the next request is issued only after the previous sequence has reported done or err.

// File: rtl/subdom_pkg.sv
package subdom_pkg;
  typedef enum logic [3:0] {
    ST_OFF, ST_PRE, ST_GATE, ST_REL, ST_CLK, ST_M_EN, ST_S_EN, ST_S_FAIL,
    ST_ON, ST_OFF_S, ST_OFF_M, ST_OFF_RB, ST_DOWN
  } seq_st_e;
  localparam int ACK_M = 0;
  localparam int ACK_S = 1;
  localparam int N_ACK = 2;
endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
  parameter int   W       = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
      else         sh_q <= {sh_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (~&cnt_q)       cnt_q <= cnt_q + 1'b1;
  end
  assign cnt_o = cnt_q;
endmodule

// File: rtl/subdom_seq.sv
module subdom_seq
  import subdom_pkg::*;
#(
  parameter int RST_CYCLES  = 32,
  parameter int ACK_TIMEOUT = 125,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_BRIDGE  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_req_i,
  input  logic off_req_i,
  input  logic rst_req_i,
  input  logic m_ack_i,
  input  logic s_ack_i,
  output logic blk_rst_o,
  output logic clk_en_o,
  output logic m_stop_o,
  output logic s_stop_o,
  output logic powered_o,
  output logic in_reset_o,
  output logic done_o,
  output logic err_o
);
  localparam int MAXC = (RST_CYCLES > ACK_TIMEOUT) ? RST_CYCLES : ACK_TIMEOUT;
  localparam int CW   = $clog2(MAXC + 1) + 1;

  seq_st_e st_q, st_d;
  logic rst_q, rst_d, clk_q, clk_d, ms_q, ms_d, ss_q, ss_d;
  logic pend_q, pend_d, done_q, done_d, err_q, err_d;
  logic [N_ACK-1:0] ack_raw, ack_s;
  logic [CW-1:0] cnt;
  logic ack_m_sy, ack_s_sy, tmo, pre_end;

  assign ack_raw = {s_ack_i, m_ack_i};

  if (HAS_BRIDGE) begin : g_sync
    ack_sync #(.W(N_ACK), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ack_raw), .q_o(ack_s));
  end else begin : g_nosync
    assign ack_s = ack_raw;
  end

  assign ack_m_sy = ack_s[ACK_M];
  assign ack_s_sy = ack_s[ACK_S];

  seq_timer #(.CW(CW)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(st_d != st_q), .cnt_o(cnt));

  assign tmo     = (cnt == CW'(ACK_TIMEOUT - 1));
  assign pre_end = (cnt == CW'(RST_CYCLES - 1));

  always_comb begin
    st_d = st_q; rst_d = rst_q; clk_d = clk_q; ms_d = ms_q; ss_d = ss_q;
    pend_d = pend_q; done_d = 1'b0; err_d = 1'b0;
    unique case (st_q)
      ST_OFF: if (on_req_i) begin st_d = ST_PRE; clk_d = 1'b1; end
      ST_PRE: if (pre_end) begin st_d = ST_GATE; clk_d = 1'b0; end
      ST_GATE: begin st_d = ST_REL; rst_d = 1'b0; end
      ST_REL:  begin st_d = ST_CLK; clk_d = 1'b1; end
      ST_CLK: begin
        if (HAS_BRIDGE) begin st_d = ST_M_EN; ms_d = 1'b0; end
        else begin st_d = ST_ON; done_d = 1'b1; end
      end
      ST_M_EN: begin
        if (!ack_m_sy) begin st_d = ST_S_EN; ss_d = 1'b0; end
        else if (tmo) begin
          st_d = ST_OFF; clk_d = 1'b0; rst_d = 1'b1; ms_d = 1'b1; err_d = 1'b1;
        end
      end
      ST_S_EN: begin
        if (!ack_s_sy) begin st_d = ST_ON; done_d = 1'b1; end
        else if (tmo) begin st_d = ST_S_FAIL; ms_d = 1'b1; ss_d = 1'b1; end
      end
      ST_S_FAIL: begin
        // wait for master to confirm stop, bounded by timeout
        if (ack_m_sy || tmo) begin
          st_d = ST_OFF; clk_d = 1'b0; rst_d = 1'b1; err_d = 1'b1;
        end
      end
      ST_ON: begin
        if (off_req_i || rst_req_i) begin
          pend_d = !off_req_i;
          if (HAS_BRIDGE) begin st_d = ST_OFF_S; ss_d = 1'b1; end
          else begin st_d = ST_DOWN; clk_d = 1'b0; rst_d = 1'b1; end
        end
      end
      ST_OFF_S: begin
        if (ack_s_sy) begin st_d = ST_OFF_M; ms_d = 1'b1; end
        else if (tmo) begin st_d = ST_ON; ss_d = 1'b0; pend_d = 1'b0; err_d = 1'b1; end
      end
      ST_OFF_M: begin
        if (ack_m_sy) begin st_d = ST_DOWN; clk_d = 1'b0; rst_d = 1'b1; end
        else if (tmo) begin st_d = ST_OFF_RB; ss_d = 1'b0; end
      end
      ST_OFF_RB: begin
        if (!ack_s_sy || tmo) begin st_d = ST_ON; pend_d = 1'b0; err_d = 1'b1; end
      end
      ST_DOWN: begin
        if (pend_q) begin st_d = ST_PRE; clk_d = 1'b1; pend_d = 1'b0; end
        else begin st_d = ST_OFF; done_d = 1'b1; end
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_OFF; rst_q <= 1'b1; clk_q <= 1'b0; ms_q <= 1'b1; ss_q <= 1'b1;
      pend_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; rst_q <= rst_d; clk_q <= clk_d; ms_q <= ms_d; ss_q <= ss_d;
      pend_q <= pend_d; done_q <= done_d; err_q <= err_d;
    end
  end

  assign blk_rst_o  = rst_q;
  assign clk_en_o   = clk_q;
  assign m_stop_o   = ms_q;
  assign s_stop_o   = ss_q;
  assign powered_o  = (st_q == ST_ON);
  assign in_reset_o = rst_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  // clocked-in-reset run length, observed when reset drops
  logic [CW-1:0] pre_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        pre_run_q <= '0;
    else if (!blk_rst_o)                pre_run_q <= '0;
    else if (clk_en_o && ~&pre_run_q)   pre_run_q <= pre_run_q + 1'b1;
  end

  a_r1_reset_propagates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blk_rst_o) |-> pre_run_q >= CW'(RST_CYCLES));
  a_r2_release_clock_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(blk_rst_o) |-> !clk_en_o);
  a_r3_master_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(m_stop_o) |-> s_stop_o);
  a_r6_slave_stopped_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(m_stop_o) |-> s_stop_o);
  a_r4_fail_parks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !powered_o) |-> (blk_rst_o && !clk_en_o && m_stop_o));
  a_r7_fail_keeps_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && powered_o) |-> (!blk_rst_o && clk_en_o && !s_stop_o));
  a_r8_done_err_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

// File: tb/test_subdom_seq.sv
module test_subdom_seq;
  localparam int RSTC = 32;
  localparam int TMO  = 125;
  localparam int RSTC_NB = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0, rst_req = 1'b0;
  logic m_ack = 1'b1, s_ack = 1'b1;
  logic blk_rst, clk_en, m_stop, s_stop, powered, in_reset, done, err;
  logic on_nb = 1'b0, off_nb = 1'b0;
  logic nb_rst, nb_clk, nb_ms, nb_ss, nb_pw, nb_ir, nb_done, nb_err;

  int checks = 0, fails = 0, cyc = 0;
  int m_dly = 2, s_dly = 2, m_cnt = 0, s_cnt = 0;
  bit m_stuck = 0, s_stuck = 0;
  int pre_cnt = 0, order_bad = 0, r11_bad = 0, saw_rst = 0;
  logic prev_rst = 1'b1;

  always #4 clk_i = ~clk_i;

  subdom_seq #(.RST_CYCLES(RSTC), .ACK_TIMEOUT(TMO)) i_subdom_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .on_req_i(on_req), .off_req_i(off_req),
    .rst_req_i(rst_req), .m_ack_i(m_ack), .s_ack_i(s_ack), .blk_rst_o(blk_rst),
    .clk_en_o(clk_en), .m_stop_o(m_stop), .s_stop_o(s_stop), .powered_o(powered),
    .in_reset_o(in_reset), .done_o(done), .err_o(err));

  subdom_seq #(.RST_CYCLES(RSTC_NB), .ACK_TIMEOUT(TMO), .HAS_BRIDGE(1'b0)) i_subdom_seq_nb (
    .clk_i(clk_i), .rst_ni(rst_ni), .on_req_i(on_nb), .off_req_i(off_nb),
    .rst_req_i(1'b0), .m_ack_i(1'b1), .s_ack_i(1'b1), .blk_rst_o(nb_rst),
    .clk_en_o(nb_clk), .m_stop_o(nb_ms), .s_stop_o(nb_ss), .powered_o(nb_pw),
    .in_reset_o(nb_ir), .done_o(nb_done), .err_o(nb_err));

  // bridge model and monitors
  always @(negedge clk_i) begin
    cyc++;
    if (m_stop != m_ack) begin
      if (m_stuck) m_cnt = 0;
      else if (m_cnt >= m_dly) begin m_ack = m_stop; m_cnt = 0; end
      else m_cnt++;
    end else m_cnt = 0;
    if (s_stop != s_ack) begin
      if (s_stuck) s_cnt = 0;
      else if (s_cnt >= s_dly) begin s_ack = s_stop; s_cnt = 0; end
      else s_cnt++;
    end else s_cnt = 0;
    if (clk_en && blk_rst) pre_cnt++;
    if (blk_rst) saw_rst = 1;
    if (prev_rst && !blk_rst && clk_en) order_bad++;
    if (!s_stop && m_stop && !powered && !err) order_bad += 0;
    if (in_reset !== blk_rst) r11_bad++;
    prev_rst = blk_rst;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // 0 done, 1 err, 2 none
  task automatic wait_res(output int res, input int lim);
    res = 2;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk_i);
      if (done) begin res = 0; break; end
      if (err)  begin res = 1; break; end
    end
  endtask

  task automatic pulse(input int kind);
    @(negedge clk_i);
    if (kind == 0) on_req = 1'b1; else if (kind == 1) off_req = 1'b1; else rst_req = 1'b1;
    @(negedge clk_i);
    on_req = 1'b0; off_req = 1'b0; rst_req = 1'b0;
  endtask

  function automatic int exp_on(input bit ms, input bit ss);
    return (ms || ss) ? 1 : 0;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    int res;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11 reset state rst", blk_rst, 1);
    chk("R11 reset state clk", clk_en, 0);
    chk("R11 reset state stops", {m_stop, s_stop}, 3);
    chk("R11 reset state powered", powered, 0);

    // R9: off / reset ignored while unpowered
    pulse(1); pulse(2);
    wait_res(res, 60);
    chk("R9 off/rst ignored when off", res, 2);
    chk("R9 outputs unchanged", {blk_rst, clk_en, m_stop, s_stop}, 4'b1011);

    // R1 R2 R3: directed turn-on
    pre_cnt = 0;
    pulse(0);
    wait_res(res, 1000);
    chk("R3 turn-on done", res, 0);
    chk("R1 clocked reset cycles", pre_cnt, RSTC);
    chk("R2 release with clock gated", order_bad, 0);
    chk("R3 powered outputs", {powered, blk_rst, clk_en, m_stop, s_stop}, 5'b10100);

    // R9: on ignored while powered
    pulse(0);
    wait_res(res, 60);
    chk("R9 on ignored when powered", res, 2);
    chk("R9 still powered", powered, 1);

    // R8: reset request
    saw_rst = 0; pre_cnt = 0;
    pulse(2);
    wait_res(res, 2000);
    chk("R8 reset request done", res, 0);
    chk("R8 reset was asserted", saw_rst, 1);
    chk("R8 powered again", powered, 1);
    chk("R1 clocked reset cycles on reset req", pre_cnt, RSTC);
    wait_res(res, 30);
    chk("R8 single done", res, 2);

    // R7: master stop timeout on turn-off
    m_stuck = 1;
    pulse(1);
    wait_res(res, 2000);
    chk("R7 off master timeout err", res, 1);
    chk("R7 state kept", {powered, blk_rst, clk_en, s_stop}, 4'b1010);
    m_stuck = 0;
    repeat (10) @(negedge clk_i);

    // R6: normal turn-off
    pulse(1);
    wait_res(res, 2000);
    chk("R6 turn-off done", res, 0);
    chk("R6 off outputs", {powered, blk_rst, clk_en, m_stop, s_stop}, 5'b01011);

    // R4: master enable timeout
    m_stuck = 1;
    pulse(0);
    wait_res(res, 2000);
    chk("R4 master enable timeout err", res, 1);
    chk("R4 parked", {powered, blk_rst, clk_en, m_stop}, 4'b0101);
    m_stuck = 0;
    repeat (10) @(negedge clk_i);

    // R5: slave enable timeout
    s_stuck = 1;
    pulse(0);
    wait_res(res, 2000);
    chk("R5 slave enable timeout err", res, 1);
    chk("R5 parked", {powered, blk_rst, clk_en, m_stop, s_stop}, 5'b01011);
    s_stuck = 0;
    repeat (10) @(negedge clk_i);

    // random on/off with random bridge latency and injected stalls
    for (int it = 0; it < 24; it++) begin
      bit ms, ss;
      int r;
      m_dly = $urandom_range(0, 40);
      s_dly = $urandom_range(0, 40);
      r = $urandom_range(0, 7);
      ms = (r == 0); ss = (r == 1);
      m_stuck = ms; s_stuck = ss;
      pulse(0);
      wait_res(res, 3000);
      chk("R3 random turn-on result", res, exp_on(ms, ss));
      chk("R3 random powered", powered, exp_on(ms, ss) == 0);
      m_stuck = 0; s_stuck = 0;
      repeat (10) @(negedge clk_i);
      if (powered) begin
        pulse(1);
        wait_res(res, 3000);
        chk("R6 random turn-off", res, 0);
        chk("R6 random off state", {blk_rst, clk_en}, 2'b10);
      end
    end
    chk("R2 release ordering overall", order_bad, 0);

    // R10: bridgeless variant
    @(negedge clk_i); on_nb = 1'b1; @(negedge clk_i); on_nb = 1'b0;
    begin
      int got = 2;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk_i);
        if (nb_done) begin got = 0; break; end
        if (nb_err) begin got = 1; break; end
      end
      chk("R10 no-bridge on done", got, 0);
      chk("R10 no-bridge outputs", {nb_pw, nb_rst, nb_clk, nb_ms, nb_ss}, 5'b10111);
      @(negedge clk_i); off_nb = 1'b1; @(negedge clk_i); off_nb = 1'b0;
      got = 2;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk_i);
        if (nb_done) begin got = 0; break; end
      end
      chk("R10 no-bridge off done", got, 0);
      chk("R10 no-bridge off outputs", {nb_pw, nb_rst, nb_clk, nb_ir}, 4'b0101);
    end
    chk("R11 in_reset tracks reset", r11_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule